// File: doc/BRIEF.md
# Nine-Phase Scheduled Majority Ripple Adder

This block adds two 8-bit operands with a ripple chain built only from majority votes. Every storage cell belongs to one of nine timing groups. A nine-phase sequencer steps through the groups. Each group votes for one phase, keeps its result visible for the next four phases, and then reads zero for the remaining four. The carry for bit i is voted one phase after the carry for bit i-1. A carry can therefore travel along the chain one group at a time without a padding stage between slices. Copy cells in two extra places stretch operand bits and early sum bits past their four-phase window.

Software or a controller issues an addition by raising a start strobe in a cycle where the sequencer sits at phase 0. The 9-bit result is gathered in one readout cycle, ten cycles after the accepted start, and a valid flag marks that cycle. A new start can be accepted at the phase-0 cycle that begins each lap, so the block accepts one addition every nine cycles. The top slice forms its sum from two three-input votes, so the operand bits for that slice need only one copy stage.

Top module: `majadd_top`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, sum_o is 0 and sum_valid_o is 0. The sequencer starts idle at phase 0.
- R2: The sequencer phase counts 0,1,...,8 and wraps to 0, one step per cycle. At phase 0 it waits unless start_i is high or a readout is pending. start_i is taken only in a phase-0 cycle. A start raised in phases 1 through 8 is ignored and produces no result.
- R3: If a start is taken in cycle S with operands A and B, then sum_o in cycle S+10 equals A+B as a 9-bit value, with bit 8 as the carry out.
- R4: sum_valid_o is high in cycle S+10 for each taken start, for that one cycle only, and low in every other cycle.
- R5: Each output bit shows the value of its operation for four cycles. Bits 0..4 show it in S+7..S+10, bit 5 in S+8..S+11, bits 6 and 8 in S+9..S+12, and bit 7 in S+10..S+13. The bit stays unchanged inside its window.
- R6: Outside those windows every output bit reads 0. This includes idle time and laps that ran with no start taken, since such a lap votes zero operands.
- R7: A start taken in cycle S+9, the cycle just before an earlier operation's readout, is accepted. Both results are correct, so back-to-back operations complete one per nine cycles.
- R8: Group g votes during phase g. Its cells then show the voted value unchanged during phases g+1..g+4 (mod 9) and read zero in the other five phases. No cell changes while the sequencer waits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one cycle per phase |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only at phase 0 |
| a_i | input | 8 | First operand, sampled with the start |
| b_i | input | 8 | Second operand, sampled with the start |
| sum_o | output | 9 | Result bits; bit 8 is the carry out |
| sum_valid_o | output | 1 | High in the single readout cycle |

## Verification
In one phase-0 cycle, group 0 votes two things at once: the operands of a new operation and the top sum bit of the previous one. The next cycle is the readout of that previous operation. Back-to-back starts at every lap boundary force these events to coincide. Starts are also raised in the phases where they must be ignored. A behavioural model tracks the phase and each operation's visibility windows, and every output bit and the valid flag are compared against it on every cycle. The readout value in those overlapping laps decides whether the capture disturbed the previous sum.

// File: rtl/majadd_pkg.sv
package majadd_pkg;

    localparam int PHASES = 9;
    localparam int HOLD   = 4;
    localparam int WIDTH  = 8;
    localparam int PH_W   = $clog2(PHASES);
    localparam int KW     = PH_W + 1;
    localparam int RES_W  = WIDTH + 1;

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            busy;
        logic            done;
    } seq_state_t;

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

    function automatic logic maj5(input logic [4:0] v);
        logic [2:0] n;
        n = 3'(v[0]) + 3'(v[1]) + 3'(v[2]) + 3'(v[3]) + 3'(v[4]);
        return n >= 3'd3;
    endfunction

endpackage

// File: rtl/majadd_phase_seq.sv
module majadd_phase_seq
    import majadd_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    output logic [PHASES-1:0] vote_o,
    output logic [PHASES-1:0] clear_o,
    output logic [PHASES-1:0] vis_o,
    output logic              valid_o
);

    seq_state_t cur_q, nx_d;
    logic       adv;

    always_comb begin
        nx_d = cur_q;
        adv  = (cur_q.phase != '0) || start_i || cur_q.busy;
        if (adv) begin
            nx_d.phase = (cur_q.phase == PH_W'(PHASES - 1)) ? '0 : cur_q.phase + PH_W'(1);
        end
        if ((cur_q.phase == '0) && adv) begin
            nx_d.busy = start_i;
            nx_d.done = cur_q.busy;
        end else if (cur_q.phase == PH_W'(1)) begin
            nx_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cur_q <= '0;
        else         cur_q <= nx_d;
    end

    // per-group state decode: k is the phase offset of the group
    for (genvar g = 0; g < PHASES; g++) begin : gen_grp
        logic [KW-1:0]   sum_w;
        logic [PH_W-1:0] k;
        assign sum_w      = {1'b0, cur_q.phase} + KW'(PHASES - g);
        assign k          = (sum_w >= KW'(PHASES)) ? PH_W'(sum_w - KW'(PHASES)) : PH_W'(sum_w);
        assign vote_o[g]  = adv && (k == '0);
        assign clear_o[g] = adv && (k == PH_W'(HOLD));
        assign vis_o[g]   = (k != '0) && (k <= PH_W'(HOLD));
    end

    assign valid_o = cur_q.done;

    // R2: an idle sequencer without a start stays at phase 0
    p_idle_wait_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_q.phase == '0 && !start_i && !cur_q.busy) |=> (cur_q.phase == '0));

    // R4: the valid flag only appears in the readout phase
    p_valid_phase_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (cur_q.phase == PH_W'(1)));

    // R4: the valid flag lasts a single cycle
    p_valid_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

endmodule

// File: rtl/majadd_cell.sv
module majadd_cell #(
    parameter int W = 1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         vote_i,
    input  logic         clear_i,
    input  logic         vis_i,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (vote_i)       q_d = val_i;
        else if (clear_i) q_d = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= '0;
        else         q_q <= q_d;
    end

    assign q_o = q_q;

    // R8: a forgotten cell casts no vote
    p_forgot_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vis_i |-> (q_q == '0));

    // R8: a held value does not move inside its window
    p_hold_steady_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vis_i && $past(vis_i)) |-> $stable(q_q));

endmodule

// File: rtl/majadd_top.sv
module majadd_top
    import majadd_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [RES_W-1:0] sum_o,
    output logic             sum_valid_o
);

    // first operand bit whose sum vote falls after the capture window
    localparam int OPL        = HOLD - 1;
    localparam int OPN        = WIDTH - OPL;
    localparam int OP_ST_GRP  = HOLD;
    localparam int SUM_ST_N   = WIDTH - HOLD;
    localparam int SUM_ST_GRP = WIDTH - 2;

    logic [PHASES-1:0] vote, clear, vis;

    majadd_phase_seq u_seq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .vote_o  (vote),
        .clear_o (clear),
        .vis_o   (vis),
        .valid_o (sum_valid_o)
    );

    // operand capture in group 0; a lap without start votes zeros
    logic [2*WIDTH-1:0] op_val, op_q;
    logic [WIDTH-1:0]   op_a, op_b;
    assign op_val = start_i ? {b_i, a_i} : '0;

    majadd_cell #(.W(2*WIDTH)) u_op (
        .clk_i (clk_i), .rst_ni (rst_ni),
        .vote_i (vote[0]), .clear_i (clear[0]), .vis_i (vis[0]),
        .val_i (op_val), .q_o (op_q)
    );
    assign op_a = op_q[WIDTH-1:0];
    assign op_b = op_q[2*WIDTH-1:WIDTH];

    // stretch of the upper operand bits
    logic [2*OPN-1:0] late_q;
    logic [OPN-1:0]   late_a, late_b;

    majadd_cell #(.W(2*OPN)) u_op_late (
        .clk_i (clk_i), .rst_ni (rst_ni),
        .vote_i (vote[OP_ST_GRP]), .clear_i (clear[OP_ST_GRP]), .vis_i (vis[OP_ST_GRP]),
        .val_i ({op_b[WIDTH-1:OPL], op_a[WIDTH-1:OPL]}), .q_o (late_q)
    );
    assign late_a = late_q[OPN-1:0];
    assign late_b = late_q[2*OPN-1:OPN];

    logic [WIDTH-1:0] c_q;
    logic [WIDTH-1:0] s_q;

    for (genvar i = 0; i < WIDTH; i++) begin : gen_slice
        localparam int GC = (i + 1) % PHASES;
        localparam int GS = (i + 2) % PHASES;
        logic a_c, b_c, c_in;

        if (i < HOLD) begin : g_c_early
            assign a_c = op_a[i];
            assign b_c = op_b[i];
        end else begin : g_c_late
            assign a_c = late_a[i-OPL];
            assign b_c = late_b[i-OPL];
        end

        if (i == 0) begin : g_cin0
            assign c_in = 1'b0;
        end else begin : g_cin
            assign c_in = c_q[i-1];
        end

        majadd_cell #(.W(1)) u_carry (
            .clk_i (clk_i), .rst_ni (rst_ni),
            .vote_i (vote[GC]), .clear_i (clear[GC]), .vis_i (vis[GC]),
            .val_i (maj3(a_c, b_c, c_in)), .q_o (c_q[i])
        );

        if (i < WIDTH - 1) begin : g_sum5
            logic a_s, b_s;
            if (i < OPL) begin : g_s_early
                assign a_s = op_a[i];
                assign b_s = op_b[i];
            end else begin : g_s_late
                assign a_s = late_a[i-OPL];
                assign b_s = late_b[i-OPL];
            end
            majadd_cell #(.W(1)) u_sum (
                .clk_i (clk_i), .rst_ni (rst_ni),
                .vote_i (vote[GS]), .clear_i (clear[GS]), .vis_i (vis[GS]),
                .val_i (maj5({a_s, b_s, c_in, ~c_q[i], ~c_q[i]})), .q_o (s_q[i])
            );
        end else begin : g_sum_top
            // two three-input votes: no operand needed after the carry vote
            logic u_q;
            majadd_cell #(.W(1)) u_aux (
                .clk_i (clk_i), .rst_ni (rst_ni),
                .vote_i (vote[GC]), .clear_i (clear[GC]), .vis_i (vis[GC]),
                .val_i (maj3(a_c, b_c, ~c_in)), .q_o (u_q)
            );
            majadd_cell #(.W(1)) u_sum (
                .clk_i (clk_i), .rst_ni (rst_ni),
                .vote_i (vote[GS]), .clear_i (clear[GS]), .vis_i (vis[GS]),
                .val_i (maj3(u_q, ~c_q[i], c_in)), .q_o (s_q[i])
            );
        end
    end

    // stretch of the early sum bits into the readout window
    logic [SUM_ST_N-1:0] s_st_q;

    majadd_cell #(.W(SUM_ST_N)) u_sum_late (
        .clk_i (clk_i), .rst_ni (rst_ni),
        .vote_i (vote[SUM_ST_GRP]), .clear_i (clear[SUM_ST_GRP]), .vis_i (vis[SUM_ST_GRP]),
        .val_i (s_q[SUM_ST_N-1:0]), .q_o (s_st_q)
    );

    assign sum_o = {c_q[WIDTH-1], s_q[WIDTH-1:SUM_ST_N], s_st_q};

endmodule

// File: tb/sim_majadd_top.sv
module sim_majadd_top;

    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       start = 1'b0;
    logic [7:0] a_in = '0;
    logic [7:0] b_in = '0;
    logic [8:0] sum_o;
    logic       sum_valid;

    always #5 clk = ~clk;

    majadd_top u0 (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .start_i     (start),
        .a_i         (a_in),
        .b_i         (b_in),
        .sum_o       (sum_o),
        .sum_valid_o (sum_valid)
    );

    typedef struct {
        int         s;
        logic [8:0] v;
    } op_t;

    op_t ops[$];
    int  checks = 0;
    int  fails = 0;
    int  cyc = 0;
    int  ph = 0;
    bit  busy = 0;
    bit  b2b_mode = 0;
    bit  finished = 0;
    int  obs_pulses = 0;
    int  exp_pulses = 0;

    function automatic int win_lo(input int j);
        if (j <= 4) return 7;
        if (j == 5) return 8;
        if (j == 7) return 10;
        return 9;
    endfunction

    task automatic report(input bit ok, input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic check_now();
        logic [8:0] er;
        bit ev;
        int d;
        er = '0;
        ev = 1'b0;
        foreach (ops[n]) begin
            d = cyc - ops[n].s;
            if (d == 10) ev = 1'b1;
            for (int j = 0; j < 9; j++) begin
                if (d >= win_lo(j) && d <= win_lo(j) + 3) er[j] = ops[n].v[j];
            end
        end
        report(sum_valid === ev, "R4 valid flag", 9'(sum_valid), 9'(ev));
        if (ev)
            report(sum_o === er, b2b_mode ? "R7 back-to-back sum" : "R3 readout sum", sum_o, er);
        else if (er != '0)
            report(sum_o === er, "R5 bit window (R8 group hold)", sum_o, er);
        else
            report(sum_o === er, "R6 forgotten bits", sum_o, er);
        if (sum_valid === 1'b1) obs_pulses++;
        if (ev) exp_pulses++;
        while (ops.size() > 0 && (cyc - ops[0].s) > 13) void'(ops.pop_front());
    endtask

    task automatic tick(input bit st, input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        if (finished) return;
        check_now();
        start = st;
        a_in  = a;
        b_in  = b;
        if (ph == 0) begin
            if (st || busy) begin
                if (st) ops.push_back('{cyc, 9'(a) + 9'(b)});
                busy = st;
                ph   = 1;
            end
        end else begin
            ph = (ph == 8) ? 0 : ph + 1;
        end
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick(1'b0, 8'($urandom), 8'($urandom));
    endtask

    task automatic issue(input logic [7:0] a, input logic [7:0] b, input bit noisy);
        while (ph != 0) tick(noisy, 8'($urandom), 8'($urandom));
        tick(1'b1, a, b);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected done");
            finish_up();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        report(sum_o === '0, "R1 reset sum", sum_o, '0);
        report(sum_valid === 1'b0, "R1 reset valid", 9'(sum_valid), '0);
        rst_ni = 1'b1;
        cyc = 1;
        idle(1);
        report(sum_o === '0, "R1 first cycle sum", sum_o, '0);

        // R6: idle waits at phase 0 with all bits zero
        idle(12);

        // R3: directed operands
        issue(8'h00, 8'h00, 0); idle(16);
        issue(8'hFF, 8'h01, 0); idle(16);
        issue(8'hFF, 8'hFF, 0); idle(16);
        issue(8'h55, 8'hAA, 0); idle(16);
        issue(8'h80, 8'h80, 0); idle(16);
        issue(8'h01, 8'h7F, 0); idle(16);

        // R2: starts in phases 1..8 are ignored
        issue(8'h3C, 8'hC3, 0);
        while (ph != 0) tick(1'b1, 8'($urandom), 8'($urandom));
        idle(20);
        report(obs_pulses == exp_pulses, "R2 ignored starts", 9'(obs_pulses), 9'(exp_pulses));

        // R7: one start per lap, starts also raised in other phases
        b2b_mode = 1;
        for (int n = 0; n < 12; n++) issue(8'($urandom), 8'($urandom), n[0]);
        idle(16);
        b2b_mode = 0;

        // R3, R5, R6: random operands with random gaps
        for (int n = 0; n < 30; n++) begin
            issue(8'($urandom), 8'($urandom), 0);
            idle($urandom_range(0, 12));
        end
        idle(16);
        report(obs_pulses == exp_pulses, "R4 pulse count", 9'(obs_pulses), 9'(exp_pulses));
        finish_up();
    end

endmodule